// File: doc/BRIEF.md
# Address-Strobed Configuration Register

This block holds a 16-bit configuration word that software changes without ever placing data on a bus. A window of 32 consecutive processor addresses, starting at 0xFFC0, is set aside for it. Each bit of the word owns two neighbouring addresses in that window. A write cycle to the lower (even) address of a pair forces the bit to 0. A write cycle to the upper (odd) address forces it to 1. Whatever byte the processor drives during the write plays no part, and the block has no data input at all.

The stored word is presented whole, and also cut into named fields for the rest of the chip. These fields carry the video display mode, the display start offset, a page select, the processor speed mode, the memory size and the memory map type. Software builds a value one bit at a time, and each write cycle touches at most one bit. Field widths and the window base are parameters. The register width is the sum of the field widths and must be a power of two.

Top module: `strobe_cfg_reg`

## Requirements
- R1: While `rst_n` is low, all register bits read 0.
- R2: A write (`wr_en` high at a rising clock edge) to address 0xFFC0 + 2k, for k from 0 to 15, clears bit k of `cfg_q`.
- R3: A write to address 0xFFC0 + 2k + 1 sets bit k of `cfg_q`.
- R4: A write inside the window changes no bit other than bit k, which is address bits [4:1] of the offset from 0xFFC0.
- R5: A write to any address below 0xFFC0 or above 0xFFDF leaves `cfg_q` unchanged.
- R6: When `wr_en` is low, `cfg_q` holds, whatever the address.
- R7: A write becomes visible on `cfg_q` only after the rising clock edge that samples it, and not before that edge.
- R8: The fields are slices of `cfg_q`: `video_mode` = bits [2:0], `disp_offset` = bits [9:3], `page_sel` = bit 10, `speed_sel` = bits [12:11], `mem_size` = bits [14:13], `map_type` = bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all writes take effect on its rising edge |
| rst_n | input | 1 | Active-low reset; clears every bit |
| wr_en | input | 1 | Processor write strobe, active high |
| addr | input | 16 | Processor address bus |
| cfg_q | output | 16 | Whole stored configuration word |
| video_mode | output | 3 | Video display mode field |
| disp_offset | output | 7 | Display start offset field |
| page_sel | output | 1 | Page select field |
| speed_sel | output | 2 | Processor speed mode field |
| mem_size | output | 2 | Memory size field |
| map_type | output | 1 | Memory map type field |

## Verification
The bench builds the block with its default parameters: a 16-bit address bus, field widths that sum to 16 bits, a window at 0xFFC0, and asynchronous reset. Because the address bus is only 16 bits wide, the bench can drive a write to every one of the 65,536 addresses in turn and compare the word after each one against an arithmetic model. This covers both window edges, aliases of the window in lower memory, and every clear and set pair. The default field widths also let the bench check each field slice against shifted and masked values of several full-word patterns.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;

   // Default field widths, from least to most significant.
   localparam int DEF_VMODE_W = 3;
   localparam int DEF_OFFS_W  = 7;
   localparam int DEF_PAGE_W  = 1;
   localparam int DEF_SPEED_W = 2;
   localparam int DEF_MSIZE_W = 2;
   localparam int DEF_MAP_W   = 1;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

   function automatic int log2_ceil(input int v);
      int r;
      r = 0;
      while ((1 << r) < v) r++;
      return r;
   endfunction

endpackage

// File: rtl/cfgreg_win_decode.sv
module cfgreg_win_decode #(
   parameter int                ADDR_W   = 16,
   parameter int                REG_BITS = 16,
   parameter logic [ADDR_W-1:0] WIN_BASE = 16'hFFC0,
   localparam int               IDX_W    = cfgreg_pkg::log2_ceil(REG_BITS)
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [IDX_W-1:0]  bit_idx,
   output logic              bit_val
);

   localparam int TAG_LO = IDX_W + 1;

   // The window is aligned to its own span, so a hit needs only the upper bits.
   assign hit     = (addr[ADDR_W-1:TAG_LO] == WIN_BASE[ADDR_W-1:TAG_LO]);
   assign bit_idx = addr[IDX_W:1];
   assign bit_val = addr[0];

endmodule

// File: rtl/cfgreg_strobe_onehot.sv
module cfgreg_strobe_onehot #(
   parameter int  REG_BITS = 16,
   localparam int IDX_W    = cfgreg_pkg::log2_ceil(REG_BITS)
) (
   input  logic                wr_en,
   input  logic                hit,
   input  logic [IDX_W-1:0]    bit_idx,
   input  logic                bit_val,
   output logic [REG_BITS-1:0] set_en,
   output logic [REG_BITS-1:0] clr_en
);

   for (genvar i = 0; i < REG_BITS; i++) begin : g_sel
      logic pick;
      assign pick      = wr_en && hit && (bit_idx == IDX_W'(i));
      assign set_en[i] = pick &&  bit_val;
      assign clr_en[i] = pick && !bit_val;
   end

endmodule

// File: rtl/cfgreg_bit_array.sv
module cfgreg_bit_array #(
   parameter int REG_BITS    = 16,
   parameter bit RESET_ASYNC = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [REG_BITS-1:0] set_en,
   input  logic [REG_BITS-1:0] clr_en,
   output logic [REG_BITS-1:0] q
);

   for (genvar i = 0; i < REG_BITS; i++) begin : g_cell
      if (RESET_ASYNC) begin : g_async
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         q[i] <= 1'b0;
            else if (set_en[i]) q[i] <= 1'b1;
            else if (clr_en[i]) q[i] <= 1'b0;
         end
      end else begin : g_sync
         always_ff @(posedge clk) begin
            if (!rst_n)         q[i] <= 1'b0;
            else if (set_en[i]) q[i] <= 1'b1;
            else if (clr_en[i]) q[i] <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/strobe_cfg_reg.sv
module strobe_cfg_reg #(
   parameter int                ADDR_W      = 16,
   parameter logic [ADDR_W-1:0] WIN_BASE    = 16'hFFC0,
   parameter bit                RESET_ASYNC = 1'b1,
   parameter int                VMODE_W     = cfgreg_pkg::DEF_VMODE_W,
   parameter int                OFFS_W      = cfgreg_pkg::DEF_OFFS_W,
   parameter int                PAGE_W      = cfgreg_pkg::DEF_PAGE_W,
   parameter int                SPEED_W     = cfgreg_pkg::DEF_SPEED_W,
   parameter int                MSIZE_W     = cfgreg_pkg::DEF_MSIZE_W,
   parameter int                MAP_W       = cfgreg_pkg::DEF_MAP_W,
   localparam int               REG_BITS    = VMODE_W + OFFS_W + PAGE_W + SPEED_W + MSIZE_W + MAP_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   addr,
   output logic [REG_BITS-1:0] cfg_q,
   output logic [VMODE_W-1:0]  video_mode,
   output logic [OFFS_W-1:0]   disp_offset,
   output logic [PAGE_W-1:0]   page_sel,
   output logic [SPEED_W-1:0]  speed_sel,
   output logic [MSIZE_W-1:0]  mem_size,
   output logic [MAP_W-1:0]    map_type
);

   localparam int IDX_W    = cfgreg_pkg::log2_ceil(REG_BITS);
   localparam int SPAN     = 2 * REG_BITS;
   localparam int VMODE_LO = 0;
   localparam int OFFS_LO  = VMODE_LO + VMODE_W;
   localparam int PAGE_LO  = OFFS_LO + OFFS_W;
   localparam int SPEED_LO = PAGE_LO + PAGE_W;
   localparam int MSIZE_LO = SPEED_LO + SPEED_W;
   localparam int MAP_LO   = MSIZE_LO + MSIZE_W;

   // Elaboration-time parameter checks
   if (!cfgreg_pkg::is_pow2(REG_BITS)) begin : g_chk_width
      $error("strobe_cfg_reg: field widths must sum to a power of two");
   end
   if (ADDR_W <= IDX_W + 1) begin : g_chk_addr
      $error("strobe_cfg_reg: address bus too narrow for the window");
   end
   if ((int'(WIN_BASE) % SPAN) != 0) begin : g_chk_align
      $error("strobe_cfg_reg: window base must be aligned to twice the register width");
   end

   logic                hit;
   logic [IDX_W-1:0]    bit_idx;
   logic                bit_val;
   logic [REG_BITS-1:0] set_en;
   logic [REG_BITS-1:0] clr_en;

   cfgreg_win_decode #(
      .ADDR_W   (ADDR_W),
      .REG_BITS (REG_BITS),
      .WIN_BASE (WIN_BASE)
   ) u_dec (
      .addr    (addr),
      .hit     (hit),
      .bit_idx (bit_idx),
      .bit_val (bit_val)
   );

   cfgreg_strobe_onehot #(
      .REG_BITS (REG_BITS)
   ) u_sel (
      .wr_en   (wr_en),
      .hit     (hit),
      .bit_idx (bit_idx),
      .bit_val (bit_val),
      .set_en  (set_en),
      .clr_en  (clr_en)
   );

   cfgreg_bit_array #(
      .REG_BITS    (REG_BITS),
      .RESET_ASYNC (RESET_ASYNC)
   ) u_bits (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (set_en),
      .clr_en (clr_en),
      .q      (cfg_q)
   );

   assign video_mode  = cfg_q[VMODE_LO +: VMODE_W];
   assign disp_offset = cfg_q[OFFS_LO  +: OFFS_W];
   assign page_sel    = cfg_q[PAGE_LO  +: PAGE_W];
   assign speed_sel   = cfg_q[SPEED_LO +: SPEED_W];
   assign mem_size    = cfg_q[MSIZE_LO +: MSIZE_W];
   assign map_type    = cfg_q[MAP_LO   +: MAP_W];

endmodule

// File: rtl/strobe_cfg_reg_chk.sv
module strobe_cfg_reg_chk #(
   parameter int                ADDR_W   = 16,
   parameter int                REG_BITS = 16,
   parameter logic [ADDR_W-1:0] WIN_BASE = 16'hFFC0
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic [ADDR_W-1:0]   addr,
   input logic [REG_BITS-1:0] cfg_q
);

   localparam logic [ADDR_W-1:0] SPAN_A = ADDR_W'(2 * REG_BITS);

   // Independent window model: subtract the base, then compare against the span.
   logic [ADDR_W-1:0]   offs;
   logic                in_win;
   logic [REG_BITS-1:0] sel_mask;
   logic                rst_seen = 1'b0;

   assign offs   = addr - WIN_BASE;
   assign in_win = (addr >= WIN_BASE) && (offs < SPAN_A) && (offs[0] || !offs[0]);

   always_comb begin
      for (int i = 0; i < REG_BITS; i++) begin
         sel_mask[i] = in_win && (offs[ADDR_W-1:1] == (ADDR_W-1)'(i));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rst_seen <= 1'b1;
   end

   // R1: the word reads zero while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n && rst_seen) begin
         assert_reset_clear_R1: assert (cfg_q == '0)
            else $error("R1: cfg_q not zero during reset");
      end
   end

   // R2: even address of a pair clears the selected bit
   assert_even_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && in_win && !offs[0]) |=> ((cfg_q & $past(sel_mask)) == '0));

   // R3: odd address of a pair sets the selected bit
   assert_odd_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && in_win && offs[0]) |=> ((cfg_q & $past(sel_mask)) != '0));

   // R4: a window write leaves every other bit as it was
   assert_single_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && in_win) |=> (((cfg_q ^ $past(cfg_q)) & ~$past(sel_mask)) == '0));

   // R5: writes outside the window have no effect
   assert_outside_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !in_win) |=> $stable(cfg_q));

   // R6: no strobe, no change
   assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(cfg_q));

endmodule

bind strobe_cfg_reg strobe_cfg_reg_chk #(
   .ADDR_W   (ADDR_W),
   .REG_BITS (REG_BITS),
   .WIN_BASE (WIN_BASE)
) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .wr_en (wr_en),
   .addr  (addr),
   .cfg_q (cfg_q)
);

// File: tb/strobe_cfg_reg_test.sv
`timescale 1ns/1ps
module strobe_cfg_reg_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] addr = 16'h0000;
   logic [15:0] cfg_q;
   logic [2:0]  video_mode;
   logic [6:0]  disp_offset;
   logic [0:0]  page_sel;
   logic [1:0]  speed_sel;
   logic [1:0]  mem_size;
   logic [0:0]  map_type;

   int   n_checks = 0;
   int   n_fails  = 0;
   bit   done     = 1'b0;
   logic [15:0] exp_q = 16'h0000;

   always #2.5 clk = ~clk;

   strobe_cfg_reg uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .addr        (addr),
      .cfg_q       (cfg_q),
      .video_mode  (video_mode),
      .disp_offset (disp_offset),
      .page_sel    (page_sel),
      .speed_sel   (speed_sel),
      .mem_size    (mem_size),
      .map_type    (map_type)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Model of one write, straight from R2/R3/R5
   function automatic logic [15:0] model(input logic [15:0] cur, input logic [15:0] a);
      logic [15:0] r;
      r = cur;
      if (a >= 16'hFFC0 && a <= 16'hFFDF) r[(a - 16'hFFC0) >> 1] = a[0];
      return r;
   endfunction

   function automatic string tag_of(input logic [15:0] a);
      if (a < 16'hFFC0 || a > 16'hFFDF) return "R5 outside window";
      if (a[0]) return "R3/R4 odd sets";
      return "R2/R4 even clears";
   endfunction

   // One write cycle; checks the pre-edge value (R7) and the post-edge value
   task automatic wr(input logic [15:0] a, input string tag);
      @(negedge clk);
      addr  = a;
      wr_en = 1'b1;
      #1;
      chk({"R7 before edge, ", tag}, cfg_q, exp_q);
      exp_q = model(exp_q, a);
      @(posedge clk);
      #1;
      chk(tag, cfg_q, exp_q);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic load(input logic [15:0] v);
      for (int k = 0; k < 16; k++) wr(16'hFFC0 + 16'(2 * k) + 16'(v[k]), "load pattern");
   endtask

   task automatic chk_fields(input logic [15:0] v);
      chk("R8 video_mode",  16'(video_mode),  v & 16'h0007);
      chk("R8 disp_offset", 16'(disp_offset), (v >> 3) & 16'h007F);
      chk("R8 page_sel",    16'(page_sel),    (v >> 10) & 16'h0001);
      chk("R8 speed_sel",   16'(speed_sel),   (v >> 11) & 16'h0003);
      chk("R8 mem_size",    16'(mem_size),    (v >> 13) & 16'h0003);
      chk("R8 map_type",    16'(map_type),    (v >> 15) & 16'h0001);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset state", cfg_q, 16'h0000);
      chk_fields(16'h0000);
      @(negedge clk);
      rst_n = 1'b1;

      // R3 then R2 for each bit, walking through the window
      for (int k = 0; k < 16; k++) wr(16'hFFC1 + 16'(2 * k), "R3 set single bit");
      chk("R3 all bits set", cfg_q, 16'hFFFF);
      for (int k = 0; k < 16; k++) wr(16'hFFC0 + 16'(2 * k), "R2 clear single bit");
      chk("R2 all bits clear", cfg_q, 16'h0000);

      // Window edges and aliases (R5)
      load(16'h8001);
      wr(16'hFFBF, "R5 just below window");
      wr(16'hFFE0, "R5 just above window");
      wr(16'hFFE1, "R5 above window odd");
      wr(16'h7FC1, "R5 alias of window");
      wr(16'hFFFF, "R5 top of space");

      // R6: strobe idle with window addresses
      load(16'h5A3C);
      for (int a = 16'hFFC0; a <= 16'hFFDF; a++) begin
         @(negedge clk);
         addr  = 16'(a);
         wr_en = 1'b0;
         @(posedge clk);
         #1;
         chk("R6 strobe low holds", cfg_q, exp_q);
      end

      // R8 field slicing for several patterns
      load(16'hA5C3); chk_fields(16'hA5C3);
      load(16'h5A3C); chk_fields(16'h5A3C);
      load(16'hFFFF); chk_fields(16'hFFFF);
      load(16'h1248); chk_fields(16'h1248);

      // Exhaustive address sweep with the strobe held high
      for (int a = 0; a < 65536; a++) begin
         @(negedge clk);
         addr  = 16'(a);
         wr_en = 1'b1;
         exp_q = model(exp_q, 16'(a));
         @(posedge clk);
         #1;
         chk(tag_of(16'(a)), cfg_q, exp_q);
      end
      @(negedge clk);
      wr_en = 1'b0;

      // R1: reset during operation
      load(16'hC3A5);
      @(negedge clk);
      rst_n = 1'b0;
      exp_q = 16'h0000;
      @(posedge clk);
      #1;
      chk("R1 reset mid-run", cfg_q, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;
      wr(16'hFFC9, "R3 write after reset");
      chk("R3 bit 4 after reset", cfg_q, 16'h0010);

      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (150000) @(posedge clk);
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule